// File: doc/BRIEF.md
# Bus Target Transfer Policy Controller

This block decides how a bus bridge answers a cycle in which the bridge is the target. When a cycle starts, it reads a control byte and the state of the bridge's outbound write buffers, and picks one of four responses. It can turn the cycle away with a retry. It can accept the cycle and stop it after the first data phase. It can accept the cycle and let multiple data phases run. For a read, it can also ask the memory side to fetch a whole cache line. For a write-and-invalidate write, it can also enable bursting on the internal bus.

The control byte lives in a small register inside the block. A write strobe loads it, and it can be read back. The bus front end reports four things: the start of each target cycle, the command code, the direction, and each data transfer and cycle end. The block returns its decision as levels that hold for the length of the cycle, plus a one-clock line-read pulse. Pin-level bus timing, the buffer storage and the memory controller belong to other blocks.

Top module: `tgt_policy_ctl`

## Requirements
- R1: After reset, the control byte reads 0x00 and the retry, disconnect, line-read and burst outputs are all low.
- R2: A write to the control byte loads bits 6:1 as written. Bits 7 and 0 always read back as 0. The register's read value is on `ctl_rdata` in the clock after the write edge.
- R3: If control bit 4 (retry-while-pending) is 1 and `obuf_pending` is high when a cycle starts, `tgt_retry` rises in the next clock and stays high until `cyc_end`. While it is high, disconnect, line-read and burst stay low.
- R4: If control bit 4 is 0, a cycle that starts with `obuf_pending` high is accepted, and no retry is given.
- R5: If control bit 6 (single write) is 1, an accepted write holds `tgt_disconnect` high from the clock after the start until the first `data_xfer`. If bit 6 is 0, `tgt_disconnect` stays low through every data phase of the write.
- R6: If control bit 5 (single read) is 1, an accepted read holds `tgt_disconnect` high from the clock after the start until the first `data_xfer`. If bit 5 is 0, `tgt_disconnect` stays low through every data phase of the read.
- R7: `line_rd_req` is a one-clock pulse in the clock after an accepted read starts. It fires when control bit 2 is 1, or when the command is read-multiple (0xC) or memory-read-line (0xE). It never fires for a write or for a retried cycle. A plain memory read (0x6) with bit 2 at 0 gives no pulse.
- R8: `ibus_burst_en` is high during an accepted write with command 0xF (write-and-invalidate) when control bit 1 is 1. It is low for reads and for other write commands, whatever bit 1 holds. It drops after `cyc_end`.
- R9: `wbuf_en` follows control bit 3.
- R10: A `cyc_start` that arrives while a cycle is still open is ignored. The outputs keep their values and no new line-read pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read value |
| cyc_start | input | 1 | One-clock strobe when a target cycle begins |
| cyc_cmd | input | 4 | Bus command code of the starting cycle |
| cyc_is_write | input | 1 | 1 when the starting cycle is a write |
| obuf_pending | input | 1 | Outbound write buffers hold data |
| data_xfer | input | 1 | A data phase completes this clock |
| cyc_end | input | 1 | The current target cycle ends this clock |
| tgt_retry | output | 1 | Answer the open cycle with retry |
| tgt_disconnect | output | 1 | Stop the open cycle with its next data transfer |
| line_rd_req | output | 1 | One-clock request for a cache-line read |
| ibus_burst_en | output | 1 | Internal-bus burst enable for the open write |
| wbuf_en | output | 1 | Target write buffer enable |

## Verification
The hardest state to reach from the ports is a second `cyc_start` that lands while a cycle is still open, such as during a retry or an accepted burst write. In that state the fresh start would otherwise produce a new decision. The bench opens a cycle on purpose and then, before `cyc_end`, pulses `cyc_start` with a read command that would normally ask for a line read. It then checks that every output is unchanged. Random control bytes, commands and pending flags cover the mixed retry, single-phase and line-read combinations. Directed cases are added for reserved-bit readback and for plain memory reads.

// File: rtl/tgt_policy_pkg.sv
package tgt_policy_pkg;

   localparam int CTL_W = 8;

   typedef struct packed {
      logic rsvd7;
      logic single_wr;
      logic single_rd;
      logic retry_pend;
      logic wbuf_on;
      logic line_rd;
      logic wbi_burst;
      logic rsvd0;
   } ctl_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCEPT = 2'd1,
      ST_RETRY  = 2'd2
   } tstate_t;

   typedef struct packed {
      logic retry;
      logic single;
      logic line;
      logic burst;
   } decision_t;

endpackage

// File: rtl/tgt_policy_ctlreg.sv
module tgt_policy_ctlreg
   import tgt_policy_pkg::*;
#(
   parameter logic [CTL_W-1:0] RW_MASK = 8'h7E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output ctl_t             ctl,
   output logic [CTL_W-1:0] rdata
);
   logic [CTL_W-1:0] ctl_q;

   generate
      for (genvar b = 0; b < CTL_W; b++) begin : g_bit
         if (RW_MASK[b]) begin : g_rw
            always_ff @(posedge clk) begin
               if (!rst_n)  ctl_q[b] <= 1'b0;
               else if (we) ctl_q[b] <= wdata[b];
            end
         end else begin : g_ro
            assign ctl_q[b] = 1'b0;
         end
      end
   endgenerate

   assign ctl   = ctl_t'(ctl_q);
   assign rdata = ctl_q;

   a_r2_load_rw: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((rdata & RW_MASK) == ($past(wdata) & RW_MASK)));
   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |=> (rdata == '0));
endmodule

// File: rtl/tgt_policy_decide.sv
module tgt_policy_decide
   import tgt_policy_pkg::*;
#(
   parameter int CMD_W = 4,
   parameter logic [CMD_W-1:0] CMD_RD_MULT = 4'hC,
   parameter logic [CMD_W-1:0] CMD_RD_LINE = 4'hE,
   parameter logic [CMD_W-1:0] CMD_WR_INV  = 4'hF
) (
   input  ctl_t             ctl,
   input  logic [CMD_W-1:0] cmd,
   input  logic             is_write,
   input  logic             pending,
   output decision_t        dec
);
   logic line_cmd;
   logic inv_cmd;

   assign line_cmd = (cmd == CMD_RD_MULT) || (cmd == CMD_RD_LINE);
   assign inv_cmd  = (cmd == CMD_WR_INV);

   always_comb begin
      dec.retry  = ctl.retry_pend & pending;
      dec.single = is_write ? ctl.single_wr : ctl.single_rd;
      dec.line   = ~is_write & (ctl.line_rd | line_cmd) & ~dec.retry;
      dec.burst  = is_write & ctl.wbi_burst & inv_cmd & ~dec.retry;
   end
endmodule

// File: rtl/tgt_policy_seq.sv
module tgt_policy_seq
   import tgt_policy_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  decision_t dec,
   input  logic      data_xfer,
   input  logic      cyc_end,
   output logic      retry,
   output logic      disconnect,
   output logic      line_req,
   output logic      burst_en
);
   tstate_t st_q;
   logic    single_q;
   logic    burst_q;
   logic    line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         single_q <= 1'b0;
         burst_q  <= 1'b0;
         line_q   <= 1'b0;
      end else begin
         line_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start) begin
               if (dec.retry) begin
                  st_q     <= ST_RETRY;
                  single_q <= 1'b0;
                  burst_q  <= 1'b0;
               end else begin
                  st_q     <= ST_ACCEPT;
                  single_q <= dec.single;
                  burst_q  <= dec.burst;
                  line_q   <= dec.line;
               end
            end
            ST_ACCEPT: begin
               if (cyc_end) begin
                  st_q     <= ST_IDLE;
                  single_q <= 1'b0;
                  burst_q  <= 1'b0;
               end else if (single_q && data_xfer) begin
                  single_q <= 1'b0;
               end
            end
            ST_RETRY: if (cyc_end) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign retry      = (st_q == ST_RETRY);
   assign disconnect = (st_q == ST_ACCEPT) & single_q;
   assign burst_en   = (st_q == ST_ACCEPT) & burst_q;
   assign line_req   = line_q;

   a_r3_retry_excl: assert property (@(posedge clk) disable iff (!rst_n)
      retry |-> (!disconnect && !line_req && !burst_en));
   a_r7_line_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      line_req |=> !line_req);
   a_r7_line_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      line_req |-> $past(start));
   a_r5_disc_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (disconnect && data_xfer) |=> !disconnect);
   a_r3_retry_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (retry && !cyc_end) |=> retry);
   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_en && start && !cyc_end) |=> (burst_en && !line_req));
endmodule

// File: rtl/tgt_policy_ctl.sv
module tgt_policy_ctl
   import tgt_policy_pkg::*;
#(
   parameter int CMD_W = 4,
   parameter logic [CMD_W-1:0] CMD_RD_MULT = 4'hC,
   parameter logic [CMD_W-1:0] CMD_RD_LINE = 4'hE,
   parameter logic [CMD_W-1:0] CMD_WR_INV  = 4'hF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   input  logic             cyc_start,
   input  logic [CMD_W-1:0] cyc_cmd,
   input  logic             cyc_is_write,
   input  logic             obuf_pending,
   input  logic             data_xfer,
   input  logic             cyc_end,
   output logic             tgt_retry,
   output logic             tgt_disconnect,
   output logic             line_rd_req,
   output logic             ibus_burst_en,
   output logic             wbuf_en
);
   localparam logic [CTL_W-1:0] RW_BITS = 8'h7E;

   generate
      if (CMD_W < 4) begin : g_bad_cmd_w
         $error("tgt_policy_ctl: CMD_W must be at least 4");
      end
      if (CMD_RD_MULT == CMD_RD_LINE) begin : g_bad_codes
         $error("tgt_policy_ctl: read command codes must differ");
      end
   endgenerate

   ctl_t      ctl;
   decision_t dec;

   tgt_policy_ctlreg #(.RW_MASK(RW_BITS)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
      .ctl(ctl), .rdata(ctl_rdata)
   );

   tgt_policy_decide #(
      .CMD_W(CMD_W), .CMD_RD_MULT(CMD_RD_MULT),
      .CMD_RD_LINE(CMD_RD_LINE), .CMD_WR_INV(CMD_WR_INV)
   ) u_dec (
      .ctl(ctl), .cmd(cyc_cmd), .is_write(cyc_is_write),
      .pending(obuf_pending), .dec(dec)
   );

   tgt_policy_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(cyc_start), .dec(dec),
      .data_xfer(data_xfer), .cyc_end(cyc_end),
      .retry(tgt_retry), .disconnect(tgt_disconnect),
      .line_req(line_rd_req), .burst_en(ibus_burst_en)
   );

   assign wbuf_en = ctl.wbuf_on;

   a_r9_wbuf: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (wbuf_en == $past(ctl_wdata[3])));
   a_r4_accept_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !tgt_retry && !tgt_disconnect && !ibus_burst_en
       && !ctl_rdata[4]) |=> !tgt_retry);
endmodule

// File: tb/tgt_policy_ctl_tb.sv
module tgt_policy_ctl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic       cyc_start = 1'b0;
   logic [3:0] cyc_cmd = '0;
   logic       cyc_is_write = 1'b0;
   logic       obuf_pending = 1'b0;
   logic       data_xfer = 1'b0;
   logic       cyc_end = 1'b0;
   logic       tgt_retry, tgt_disconnect, line_rd_req, ibus_burst_en, wbuf_en;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   tgt_policy_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .cyc_start(cyc_start), .cyc_cmd(cyc_cmd),
      .cyc_is_write(cyc_is_write), .obuf_pending(obuf_pending),
      .data_xfer(data_xfer), .cyc_end(cyc_end), .tgt_retry(tgt_retry),
      .tgt_disconnect(tgt_disconnect), .line_rd_req(line_rd_req),
      .ibus_burst_en(ibus_burst_en), .wbuf_en(wbuf_en)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // packed expectation {retry, disconnect, line, burst}
   function automatic logic [3:0] model(input logic [7:0] c, input logic wr,
                                        input logic [3:0] cmd, input logic pend);
      logic r, d, l, b;
      r = c[4] & pend;
      d = ~r & (wr ? c[6] : c[5]);
      l = ~r & ~wr & (c[2] | cmd == 4'hC | cmd == 4'hE);
      b = ~r & wr & c[1] & (cmd == 4'hF);
      return {r, d, l, b};
   endfunction

   function automatic logic [3:0] outs();
      return {tgt_retry, tgt_disconnect, line_rd_req, ibus_burst_en};
   endfunction

   task automatic wr_ctl(input logic [7:0] v);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic run_cycle(input logic [7:0] c, input logic wr, input logic [3:0] cmd,
                            input logic pend, input int nphase, input logic intrude);
      logic [3:0] e;
      e = model(c, wr, cmd, pend);
      @(negedge clk);
      cyc_start = 1'b1; cyc_is_write = wr; cyc_cmd = cmd; obuf_pending = pend;
      @(negedge clk);
      cyc_start = 1'b0;
      chk("R3/R4/R5/R6/R7/R8 decision", {4'h0, outs()}, {4'h0, e});
      if (intrude) begin
         // R10: restart attempt while open, with a line-read command
         cyc_start = 1'b1; cyc_is_write = 1'b0; cyc_cmd = 4'hE; obuf_pending = 1'b0;
         @(negedge clk);
         cyc_start = 1'b0;
         chk("R10 start ignored", {4'h0, outs()}, {4'h0, e[3:2], 1'b0, e[0]});
      end else begin
         @(negedge clk);
         chk("R7 pulse one clock", {7'h0, line_rd_req}, 8'h0);
      end
      for (int p = 0; p < nphase; p++) begin
         data_xfer = 1'b1;
         @(negedge clk);
         data_xfer = 1'b0;
         chk(wr ? "R5 after data" : "R6 after data", {7'h0, tgt_disconnect}, 8'h0);
         chk("R3/R8 held", {6'h0, tgt_retry, ibus_burst_en}, {6'h0, e[3], e[0]});
      end
      cyc_end = 1'b1;
      @(negedge clk);
      cyc_end = 1'b0;
      chk("R3/R8 released at end", {4'h0, outs()}, 8'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ctl reset", ctl_rdata, 8'h00);
      chk("R1 outputs reset", {4'h0, outs()}, 8'h0);

      wr_ctl(8'hFF);
      chk("R2 reserved bits zero", ctl_rdata, 8'h7E);
      chk("R9 wbuf on", {7'h0, wbuf_en}, 8'h1);
      wr_ctl(8'h81);
      chk("R2 reserved only", ctl_rdata, 8'h00);
      chk("R9 wbuf off", {7'h0, wbuf_en}, 8'h0);

      // R4: pending data, no forced retry
      wr_ctl(8'h00);
      run_cycle(8'h00, 1'b0, 4'h6, 1'b1, 3, 1'b0);
      // R3: forced retry
      wr_ctl(8'h10);
      run_cycle(8'h10, 1'b0, 4'hC, 1'b1, 0, 1'b0);
      // R5/R6 single modes, and multi-phase when clear
      wr_ctl(8'h40);
      run_cycle(8'h40, 1'b1, 4'h7, 1'b0, 1, 1'b0);
      run_cycle(8'h40, 1'b0, 4'h6, 1'b0, 3, 1'b0);
      wr_ctl(8'h20);
      run_cycle(8'h20, 1'b0, 4'h6, 1'b0, 1, 1'b0);
      run_cycle(8'h20, 1'b1, 4'h7, 1'b0, 2, 1'b0);
      // R7 plain memory read gives no pulse; line command does
      wr_ctl(8'h00);
      run_cycle(8'h00, 1'b0, 4'h6, 1'b0, 1, 1'b0);
      run_cycle(8'h00, 1'b0, 4'hE, 1'b0, 1, 1'b0);
      // R8 burst on invalidate write, not on read
      wr_ctl(8'h02);
      run_cycle(8'h02, 1'b1, 4'hF, 1'b0, 2, 1'b0);
      run_cycle(8'h02, 1'b0, 4'hF, 1'b0, 1, 1'b0);
      // R10 intrusions during burst write and during retry
      run_cycle(8'h02, 1'b1, 4'hF, 1'b0, 1, 1'b1);
      wr_ctl(8'h10);
      run_cycle(8'h10, 1'b1, 4'h7, 1'b1, 0, 1'b1);

      for (int i = 0; i < 300; i++) begin
         logic [7:0] c;
         c = 8'($urandom()) & 8'h7E;
         wr_ctl(c);
         chk("R2 random readback", ctl_rdata, c);
         run_cycle(c, 1'($urandom()), 4'($urandom()), 1'($urandom()),
                   int'($urandom_range(0, 3)), 1'($urandom_range(0, 7) == 0));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule